// File: doc/BRIEF.md
# Modem Status and Loopback Unit

This block tracks the four handshake lines of a serial port and presents them to software as one 8-bit status byte. The incoming lines (clear-to-send, data-set-ready, ring indicator, carrier detect) are active low at the pins. The block synchronizes them, shows each line's asserted level, and keeps a sticky change flag per line. Any set flag raises an interrupt request. A one-cycle read strobe from the register decoder clears the flags.

A 5-bit control word drives the four active-low handshake outputs. The same word also selects a self-test mode. In that mode the outputs are parked inactive and the control bits are fed back internally as the status levels. Software can then exercise the whole status path without touching the cable. Interrupt ranking and address decoding are done outside this block.

Top module: `mdm_status_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the status byte is 0x00 and the interrupt request is 0.
- R2: Outside loopback, status bits 4, 5, 6 and 7 equal the complement of the CTS, DSR, RI and DCD pins. A pin change reaches the status on the third rising clock edge after it is applied (two synchronizer stages plus the level register).
- R3: Status bits 0, 1 and 3 are set by any change, in either direction, of the CTS, DSR and DCD levels (bits 4, 5 and 7).
- R4: Status bit 2 is set only when the RI level (bit 6) goes from 1 to 0, that is, when the RI pin returns high. The opposite transition leaves bit 2 unchanged.
- R5: A set change flag (bits 0 to 3) stays set until the read strobe is sampled high at a clock edge. That edge clears it.
- R6: If a line changes on the same edge that a read strobe is sampled, that line's flag ends up set, not cleared.
- R7: The interrupt request is 1 exactly when at least one of status bits 0 to 3 is 1.
- R8: When control bit 4 is 0, setting control bits 0, 1, 2 and 3 drives the DTR, RTS, auxiliary-1 and auxiliary-2 outputs low. Clearing those bits drives them high.
- R9: When control bit 4 is 1, all four handshake outputs are high, whatever control bits 0 to 3 hold.
- R10: In loopback (control bit 4 = 1), status bits 4, 5, 6 and 7 take control bits 1, 0, 2 and 3 one clock edge after they are applied. The external pins then have no effect on the status byte or the interrupt.
- R11: In loopback, changes of the looped-back levels set the change flags under the same rules as R3 and R4. This includes the changes caused by entering or leaving loopback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n_i | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier detect pin, active low, asynchronous |
| ctrl_i | input | 5 | Control word: [0] DTR, [1] RTS, [2] aux 1, [3] aux 2, [4] loopback |
| status_rd_i | input | 1 | One-cycle strobe marking a status byte read |
| status_o | output | 8 | [3:0] change flags (CTS, DSR, RI trailing, DCD), [7:4] line levels |
| irq_o | output | 1 | Modem-status interrupt request |
| dtr_n_o | output | 1 | DTR output, active low |
| rts_n_o | output | 1 | RTS output, active low |
| aux1_n_o | output | 1 | Auxiliary output 1, active low |
| aux2_n_o | output | 1 | Auxiliary output 2, active low |

## Verification
The assertions check, on every cycle, several rules about the outputs:
- the interrupt equals the OR of the flags;
- the output pins follow the control word, or are parked high in loopback;
- the loopback level mapping, and that flags never drop without a read;
- that a flag only rises together with a matching level change, so the ring flag only rises when the RI level falls.

Only the bench scenarios can show the following:
- the exact synchronizer latency from the pins;
- that external pins are ignored in loopback;
- that a change which coincides with a read survives;
- the exact flag pattern for each input sequence.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int MDM_LINES = 4;

    // Line index; status bit i is the flag of line i, bit i+4 its level
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DCD = 3;

    // Control word positions
    localparam int CTL_DTR  = 0;
    localparam int CTL_RTS  = 1;
    localparam int CTL_AUX1 = 2;
    localparam int CTL_AUX2 = 3;
    localparam int CTL_LOOP = 4;
    localparam int CTL_W    = 5;

    // Lines whose flag reacts only to a 1 -> 0 level transition
    localparam logic [MDM_LINES-1:0] TRAIL_ONLY_MASK = 4'b0100;

    typedef logic [MDM_LINES-1:0] line_vec_t;

    typedef struct packed {
        line_vec_t lvl;
        line_vec_t flag;
    } mdm_state_t;

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef logic [WIDTH-1:0] word_t;

    word_t stage_d [STAGES];
    word_t stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= RST_VAL;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/mdm_loopmux.sv
module mdm_loopmux
    import mdm_pkg::*;
(
    input  line_vec_t        ext_lvl_i,
    input  logic [CTL_W-1:0] ctrl_i,
    output line_vec_t        lvl_o
);

    line_vec_t loop_lvl;

    always_comb begin
        loop_lvl          = '0;
        loop_lvl[IDX_CTS] = ctrl_i[CTL_RTS];
        loop_lvl[IDX_DSR] = ctrl_i[CTL_DTR];
        loop_lvl[IDX_RI]  = ctrl_i[CTL_AUX1];
        loop_lvl[IDX_DCD] = ctrl_i[CTL_AUX2];
        lvl_o = ctrl_i[CTL_LOOP] ? loop_lvl : ext_lvl_i;
    end

endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
    import mdm_pkg::*;
#(
    parameter logic [MDM_LINES-1:0] TRAIL_MASK = TRAIL_ONLY_MASK
) (
    input  logic      clk,
    input  logic      rst_n,
    input  line_vec_t lvl_i,
    input  logic      rd_i,
    output line_vec_t lvl_q_o,
    output line_vec_t flag_q_o
);

    mdm_state_t state_d;
    mdm_state_t state_q;
    line_vec_t  change;

    for (genvar g = 0; g < MDM_LINES; g++) begin : g_line
        if (TRAIL_MASK[g]) begin : g_trail
            assign change[g] = state_q.lvl[g] & ~lvl_i[g];
        end else begin : g_any
            assign change[g] = state_q.lvl[g] ^ lvl_i[g];
        end
    end

    always_comb begin
        state_d.lvl  = lvl_i;
        // a fresh change wins over a simultaneous read
        state_d.flag = (state_q.flag & ~{MDM_LINES{rd_i}}) | change;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign lvl_q_o  = state_q.lvl;
    assign flag_q_o = state_q.flag;

endmodule

// File: rtl/mdm_outdrv.sv
module mdm_outdrv
    import mdm_pkg::*;
(
    input  logic [CTL_W-1:0]     ctrl_i,
    output logic [MDM_LINES-1:0] pin_n_o
);

    always_comb begin
        if (ctrl_i[CTL_LOOP]) begin
            pin_n_o = '1;
        end else begin
            pin_n_o = ~ctrl_i[MDM_LINES-1:0];
        end
    end

endmodule

// File: rtl/mdm_status_unit.sv
module mdm_status_unit
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cts_n_i,
    input  logic             dsr_n_i,
    input  logic             ri_n_i,
    input  logic             dcd_n_i,
    input  logic [CTL_W-1:0] ctrl_i,
    input  logic             status_rd_i,
    output logic [7:0]       status_o,
    output logic             irq_o,
    output logic             dtr_n_o,
    output logic             rts_n_o,
    output logic             aux1_n_o,
    output logic             aux2_n_o
);

    line_vec_t pin_n_raw;
    line_vec_t pin_n_sync;
    line_vec_t ext_lvl;
    line_vec_t sel_lvl;
    line_vec_t lvl_q;
    line_vec_t flag_q;
    line_vec_t out_n;

    always_comb begin
        pin_n_raw          = '1;
        pin_n_raw[IDX_CTS] = cts_n_i;
        pin_n_raw[IDX_DSR] = dsr_n_i;
        pin_n_raw[IDX_RI]  = ri_n_i;
        pin_n_raw[IDX_DCD] = dcd_n_i;
    end

    mdm_sync #(
        .WIDTH   (MDM_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({MDM_LINES{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_n_raw),
        .sync_o  (pin_n_sync)
    );

    assign ext_lvl = ~pin_n_sync;

    mdm_loopmux u_loopmux (
        .ext_lvl_i (ext_lvl),
        .ctrl_i    (ctrl_i),
        .lvl_o     (sel_lvl)
    );

    mdm_delta #(
        .TRAIL_MASK (TRAIL_ONLY_MASK)
    ) u_delta (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (sel_lvl),
        .rd_i     (status_rd_i),
        .lvl_q_o  (lvl_q),
        .flag_q_o (flag_q)
    );

    mdm_outdrv u_outdrv (
        .ctrl_i  (ctrl_i),
        .pin_n_o (out_n)
    );

    assign status_o = {lvl_q, flag_q};
    assign irq_o    = |flag_q;
    assign dtr_n_o  = out_n[CTL_DTR];
    assign rts_n_o  = out_n[CTL_RTS];
    assign aux1_n_o = out_n[CTL_AUX1];
    assign aux2_n_o = out_n[CTL_AUX2];

endmodule

// File: rtl/mdm_status_chk.sv
module mdm_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] ctrl_i,
    input logic       status_rd_i,
    input logic [7:0] status_o,
    input logic       irq_o,
    input logic       dtr_n_o,
    input logic       rts_n_o,
    input logic       aux1_n_o,
    input logic       aux2_n_o
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_irq_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (status_o[3:0] != 4'h0));

    p_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i[4] |-> ({aux2_n_o, aux1_n_o, rts_n_o, dtr_n_o} == ~ctrl_i[3:0]));

    p_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_i[4] |-> ({aux2_n_o, aux1_n_o, rts_n_o, dtr_n_o} == 4'hF));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !status_rd_i) |=>
            ((status_o[3:0] & $past(status_o[3:0])) == $past(status_o[3:0])));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(armed_q) && $past(status_rd_i) && $stable(status_o[7:4]))
            |-> (status_o[3:0] == 4'h0));

    p_map_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(armed_q) && $past(ctrl_i[4])) |->
            (status_o[7:4] == {$past(ctrl_i[3]), $past(ctrl_i[2]),
                               $past(ctrl_i[0]), $past(ctrl_i[1])}));

    p_cts_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $rose(status_o[0])) |-> (status_o[4] != $past(status_o[4])));

    p_ri_trail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $rose(status_o[2])) |-> $fell(status_o[6]));

endmodule

bind mdm_status_unit mdm_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_i      (ctrl_i),
    .status_rd_i (status_rd_i),
    .status_o    (status_o),
    .irq_o       (irq_o),
    .dtr_n_o     (dtr_n_o),
    .rts_n_o     (rts_n_o),
    .aux1_n_o    (aux1_n_o),
    .aux2_n_o    (aux2_n_o)
);

// File: tb/mdm_status_unit_bench.sv
module mdm_status_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pins_n = 4'hF;   // [0] CTS [1] DSR [2] RI [3] DCD
    logic [4:0] ctrl = 5'h00;
    logic       rd = 1'b0;
    logic [7:0] status;
    logic       irq;
    logic       dtr_n, rts_n, aux1_n, aux2_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mdm_status_unit u_mdm_status_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .cts_n_i     (pins_n[0]),
        .dsr_n_i     (pins_n[1]),
        .ri_n_i      (pins_n[2]),
        .dcd_n_i     (pins_n[3]),
        .ctrl_i      (ctrl),
        .status_rd_i (rd),
        .status_o    (status),
        .irq_o       (irq),
        .dtr_n_o     (dtr_n),
        .rts_n_o     (rts_n),
        .aux1_n_o    (aux1_n),
        .aux2_n_o    (aux2_n)
    );

    // {ctrl[4:0], pins_n[3:0], status[7:0], irq, outs {aux2,aux1,rts,dtr}}
    localparam int NVEC = 16;
    localparam logic [21:0] VEC [NVEC] = '{
        {5'h00, 4'hF, 8'h00, 1'b0, 4'hF},  // idle
        {5'h00, 4'hE, 8'h11, 1'b1, 4'hF},  // R3 CTS asserts
        {5'h00, 4'hF, 8'h01, 1'b1, 4'hF},  // R3 CTS releases
        {5'h00, 4'hB, 8'h40, 1'b0, 4'hF},  // R4 RI asserts: no flag
        {5'h00, 4'hF, 8'h04, 1'b1, 4'hF},  // R4 RI trailing edge
        {5'h00, 4'h5, 8'hAA, 1'b1, 4'hF},  // R2 DSR+DCD
        {5'h00, 4'h5, 8'hA0, 1'b0, 4'hF},  // steady
        {5'h0F, 4'h5, 8'hA0, 1'b0, 4'h0},  // R8 all outputs low
        {5'h05, 4'h5, 8'hA0, 1'b0, 4'hA},  // R8 DTR and aux1
        {5'h10, 4'h5, 8'h0A, 1'b1, 4'hF},  // R11 entering loopback
        {5'h12, 4'h5, 8'h11, 1'b1, 4'hF},  // R10 RTS -> CTS level
        {5'h11, 4'h0, 8'h23, 1'b1, 4'hF},  // R10 DTR -> DSR, pins ignored
        {5'h14, 4'h0, 8'h42, 1'b1, 4'hF},  // R11 aux1 -> RI, no ring flag
        {5'h10, 4'h0, 8'h04, 1'b1, 4'hF},  // R11 ring trailing in loop
        {5'h18, 4'hF, 8'h88, 1'b1, 4'hF},  // R10 aux2 -> DCD
        {5'h00, 4'hF, 8'h08, 1'b1, 4'hF}   // R11 leaving loopback
    };

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_read();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] snap;
        repeat (3) @(negedge clk);
        check8("R1 status in reset", status, 8'h00);
        check8("R1 irq in reset", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check8("R1 status after reset", status, 8'h00);
        check8("R1 irq after reset", {7'd0, irq}, 8'h00);

        for (int v = 0; v < NVEC; v++) begin
            ctrl   = VEC[v][21:17];
            pins_n = VEC[v][16:13];
            repeat (4) @(negedge clk);
            check8("R2/R3/R4/R10/R11 status", status, VEC[v][12:5]);
            check8("R7 irq", {7'd0, irq}, {7'd0, VEC[v][4]});
            check8("R8/R9 outputs", {4'd0, aux2_n, aux1_n, rts_n, dtr_n},
                   {4'd0, VEC[v][3:0]});
            do_read();
            check8("R5 flags cleared by read", status, VEC[v][12:5] & 8'hF0);
            check8("R7 irq cleared", {7'd0, irq}, 8'h00);
        end

        // R2 latency: third edge after the pin change
        ctrl = 5'h00; pins_n = 4'hF;
        repeat (4) @(negedge clk);
        do_read();
        pins_n = 4'hE;
        repeat (2) @(negedge clk);
        check8("R2 not yet visible after two edges", status, 8'h00);
        @(negedge clk);
        check8("R2 visible after third edge", status, 8'h11);

        // R5 hold without read
        repeat (20) @(negedge clk);
        check8("R5 flag held", status, 8'h11);
        do_read();
        check8("R5 cleared", status, 8'h10);

        // R10 pins ignored in loopback
        pins_n = 4'hF;
        repeat (4) @(negedge clk);
        do_read();
        ctrl = 5'h10;
        repeat (2) @(negedge clk);
        do_read();
        snap = status;
        check8("R10 loop base", snap, 8'h00);
        pins_n = 4'h0;
        repeat (3) @(negedge clk);
        pins_n = 4'hA;
        repeat (5) @(negedge clk);
        check8("R10 pins ignored in loop", status, snap);
        check8("R10 irq quiet in loop", {7'd0, irq}, 8'h00);

        // R6 change coinciding with read
        ctrl = 5'h12;
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        check8("R6 flag survives simultaneous read", status, 8'h11);
        do_read();
        check8("R6 later read clears", status, 8'h10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule